// File: doc/BRIEF.md
# Byte-Multiplexed ADC Conversion Sequencer

This block connects an 8-bit host write path to an external 12-bit converter whose result comes out over a shared byte-wide bus. A single host strobe carries a control byte. The sequencer writes that byte to the converter, and the write both picks the analog channel and starts the conversion. The sequencer then watches the converter's active-low completion line. When the line asserts, the sequencer fetches the result in two read cycles. The first read, with the byte-select pin low, returns bits 7:0. The second read, with the byte-select pin high, returns bits 11:8 on data lines 3:0.

The assembled sample is two's complement, with bit 11 as the sign. It is presented in its raw 12-bit form and as a 16-bit sign-extended copy, together with the channel number taken from the control byte. The sample stays valid until the host starts the next conversion. An active-low status line mirrors this state for hosts that poll. If the completion line never asserts, a wait counter gives up and raises an error flag. Host writes that arrive while a conversion is in flight are dropped, and each one is reported with a one-cycle busy pulse.

Top module: `adc_seq`

## Requirements
- R1: In reset and for the first cycle after it, adc_cs_n, adc_wr_n and adc_rd_n are 1, adc_hben and adc_data_oe are 0, smp_valid, err_timeout and busy_reject are 0, and stat_done_n is 1.
- R2: A host_wr_valid pulse while idle drives the host byte on adc_data_out with adc_data_oe high, and holds adc_cs_n and adc_wr_n low for exactly WR_CYCLES clocks. The converter sees exactly that byte, once.
- R3: After the write, the block waits for adc_int_n low, which passes through a two-stage synchronizer. It then reads with adc_hben=0 and adc_rd_n low to get bits 7:0, and with adc_hben=1 to get bits 11:8 from adc_data_in[3:0]. adc_data_in[7:4] of the second read has no effect on the sample.
- R4: smp_data12 holds {high nibble, low byte}. smp_data16 holds the same value sign-extended from bit 11 (for example 0x800 gives 0xF800 and 0x7FF gives 0x07FF).
- R5: smp_chan equals bits 2:0 of the control byte that started the conversion (0x48 gives 0, 0x4F gives 7).
- R6: smp_valid rises when the second read completes. It stays 1 until the next accepted host write and clears on the clock that accepts that write. stat_done_n is always its inverse (0 means a result is ready).
- R7: If the synchronized completion is not seen within TIMEOUT clocks of waiting, err_timeout goes to 1, the block returns to idle and smp_valid stays 0. err_timeout holds until the next accepted host write clears it.
- R8: If the synchronized completion is first seen in the last allowed waiting clock, the read proceeds and no error is raised. This covers the case where the converter pulls adc_int_n low exactly TIMEOUT-3 clocks into the wait. One clock later gives a timeout.
- R9: A host_wr_valid pulse while a conversion is in progress is ignored. It causes no converter write and does not change the channel of the pending sample. busy_reject is 1 for exactly the clock after that pulse.
- R10: adc_wr_n and adc_rd_n are never low together, and adc_data_oe is high only while adc_wr_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_valid | input | 1 | One-cycle host control write strobe |
| host_wr_data | input | 8 | Control byte (bits 2:0 channel) |
| adc_int_n | input | 1 | Converter completion, active low, asynchronous |
| adc_data_in | input | 8 | Converter read data bus |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_wr_n | output | 1 | Converter write strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_hben | output | 1 | Byte select: 0 low byte, 1 high nibble |
| adc_data_oe | output | 1 | Enable for the external bus driver |
| adc_data_out | output | 8 | Control byte driven toward the converter |
| smp_valid | output | 1 | Sample ready flag |
| smp_data12 | output | 12 | Raw two's-complement sample |
| smp_data16 | output | 16 | Sign-extended sample |
| smp_chan | output | 3 | Channel of the sample |
| stat_done_n | output | 1 | Active-low ready status |
| err_timeout | output | 1 | Completion wait expired |
| busy_reject | output | 1 | A host write was dropped |

## Verification
Completion arrival and wait expiry can land on the same clock. The block resolves that tie in favour of the completion. The bench's converter model pulls adc_int_n low after a chosen number of clocks. With that number set to TIMEOUT-3, the synchronized edge coincides with the last waiting clock, and the bench expects a proper sample. With TIMEOUT-2 it expects an error and no sample. Both outcomes are judged through the scoreboard at the ports, so an off-by-one in the counter or in the priority order shows up as a wrong item type.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int SMP_W  = 12;
    localparam int NIB_W  = SMP_W - BYTE_W;
    localparam int EXT_W  = 16;
    localparam int CH_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_WAIT,
        ST_RDLO,
        ST_GAP,
        ST_RDHI
    } seq_st_t;

    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic rd_n;
        logic hben;
        logic oe;
    } adc_pins_t;

    // Pin levels per sequencer phase
    function automatic adc_pins_t pins_for(input seq_st_t st);
        adc_pins_t p;
        p = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, hben: 1'b0, oe: 1'b0};
        case (st)
            ST_WR:   begin p.cs_n = 1'b0; p.wr_n = 1'b0; p.oe = 1'b1; end
            ST_RDLO: begin p.cs_n = 1'b0; p.rd_n = 1'b0; end
            ST_GAP:  begin p.cs_n = 1'b0; p.hben = 1'b1; end
            ST_RDHI: begin p.cs_n = 1'b0; p.rd_n = 1'b0; p.hben = 1'b1; end
            default: ;
        endcase
        return p;
    endfunction

    function automatic logic [EXT_W-1:0] sext(input logic [SMP_W-1:0] v);
        return {{(EXT_W-SMP_W){v[SMP_W-1]}}, v};
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!expired) cnt <= cnt + CW'(1);
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));

    // R7
    timer_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/adc_seq_asm.sv
module adc_seq_asm
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [BYTE_W-1:0] din,
    output logic [SMP_W-1:0]  sample12,
    output logic [EXT_W-1:0]  sample16
);
    logic [BYTE_W-1:0] lo_q;
    logic [NIB_W-1:0]  hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= din;
            if (cap_hi) hi_q <= din[NIB_W-1:0];
        end
    end

    assign sample12 = {hi_q, lo_q};
    assign sample16 = sext(sample12);

    // R3
    cap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cap_lo && cap_hi));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int WR_CYCLES   = 2,
    parameter int RD_CYCLES   = 2,
    parameter int TIMEOUT     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_valid,
    input  logic [BYTE_W-1:0] host_wr_data,
    input  logic              adc_int_n,
    input  logic [BYTE_W-1:0] adc_data_in,
    output logic              adc_cs_n,
    output logic              adc_wr_n,
    output logic              adc_rd_n,
    output logic              adc_hben,
    output logic              adc_data_oe,
    output logic [BYTE_W-1:0] adc_data_out,
    output logic              smp_valid,
    output logic [SMP_W-1:0]  smp_data12,
    output logic [EXT_W-1:0]  smp_data16,
    output logic [CH_W-1:0]   smp_chan,
    output logic              stat_done_n,
    output logic              err_timeout,
    output logic              busy_reject
);
    localparam int MAXC = (WR_CYCLES > RD_CYCLES) ? WR_CYCLES : RD_CYCLES;
    localparam int PW   = $clog2(MAXC + 1);

    seq_st_t           state;
    logic [PW-1:0]     ph;
    logic [BYTE_W-1:0] ctl_q;
    logic              int_s;
    logic              wait_expired;
    logic              wr_last, rd_last;
    adc_pins_t         pins;

    adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (adc_int_n),
        .dout (int_s)
    );

    adc_seq_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WAIT),
        .expired (wait_expired)
    );

    assign wr_last = (ph == PW'(WR_CYCLES - 1));
    assign rd_last = (ph == PW'(RD_CYCLES - 1));

    adc_seq_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .cap_lo   (state == ST_RDLO && rd_last),
        .cap_hi   (state == ST_RDHI && rd_last),
        .din      (adc_data_in),
        .sample12 (smp_data12),
        .sample16 (smp_data16)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ph          <= '0;
            ctl_q       <= '0;
            smp_valid   <= 1'b0;
            err_timeout <= 1'b0;
            busy_reject <= 1'b0;
        end else begin
            busy_reject <= host_wr_valid && (state != ST_IDLE);
            case (state)
                ST_IDLE: if (host_wr_valid) begin
                    ctl_q       <= host_wr_data;
                    smp_valid   <= 1'b0;
                    err_timeout <= 1'b0;
                    ph          <= '0;
                    state       <= ST_WR;
                end
                ST_WR: begin
                    ph <= wr_last ? '0 : ph + PW'(1);
                    if (wr_last) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (!int_s) begin
                        ph    <= '0;
                        state <= ST_RDLO;
                    end else if (wait_expired) begin
                        err_timeout <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                ST_RDLO: begin
                    ph <= rd_last ? '0 : ph + PW'(1);
                    if (rd_last) state <= ST_GAP;
                end
                ST_GAP: begin
                    ph    <= '0;
                    state <= ST_RDHI;
                end
                ST_RDHI: begin
                    ph <= rd_last ? '0 : ph + PW'(1);
                    if (rd_last) begin
                        smp_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign pins         = pins_for(state);
    assign adc_cs_n     = pins.cs_n;
    assign adc_wr_n     = pins.wr_n;
    assign adc_rd_n     = pins.rd_n;
    assign adc_hben     = pins.hben;
    assign adc_data_oe  = pins.oe;
    assign adc_data_out = ctl_q;
    assign smp_chan     = ctl_q[CH_W-1:0];
    assign stat_done_n  = ~smp_valid;

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!adc_wr_n && !adc_rd_n));
    // R10
    oe_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        adc_data_oe |-> (!adc_wr_n && !adc_cs_n));
    // R9
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        busy_reject |-> $past(host_wr_valid));
    // R6
    valid_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(smp_valid) |-> $past(host_wr_valid));
    // R7
    err_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_timeout) |-> ($past(state == ST_WAIT) && !smp_valid));
    // R3
    valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(smp_valid) |-> $past(state == ST_RDHI));
endmodule

// File: tb/adc_seq_tb.sv
module adc_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WRC  = 2;
    localparam int RDC  = 2;
    localparam int TOUT = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_wr_valid = 1'b0;
    logic [7:0] host_wr_data = '0;
    logic adc_int_n = 1'b1;
    logic [7:0] adc_data_in;
    logic adc_cs_n, adc_wr_n, adc_rd_n, adc_hben, adc_data_oe;
    logic [7:0] adc_data_out;
    logic smp_valid, stat_done_n, err_timeout, busy_reject;
    logic [11:0] smp_data12;
    logic [15:0] smp_data16;
    logic [2:0] smp_chan;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq #(.WR_CYCLES(WRC), .RD_CYCLES(RDC), .TIMEOUT(TOUT)) u_dut (
        .clk(clk), .rst(rst), .host_wr_valid(host_wr_valid),
        .host_wr_data(host_wr_data), .adc_int_n(adc_int_n),
        .adc_data_in(adc_data_in), .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n),
        .adc_rd_n(adc_rd_n), .adc_hben(adc_hben), .adc_data_oe(adc_data_oe),
        .adc_data_out(adc_data_out), .smp_valid(smp_valid),
        .smp_data12(smp_data12), .smp_data16(smp_data16), .smp_chan(smp_chan),
        .stat_done_n(stat_done_n), .err_timeout(err_timeout),
        .busy_reject(busy_reject)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [11:0] res12 = '0;
    int   conv_dly = 0;
    int   write_count = 0;
    int   wr_low_len = 0;
    int   last_wr_len = 0;
    logic [7:0] seen_ctl = '0;
    bit   converting = 0;
    int   mcnt = 0;
    logic prev_wr_n = 1'b1;

    // junk in the high nibble of the second read must be ignored
    assign adc_data_in = adc_hben ? {4'hA, res12[11:8]} : res12[7:0];

    always @(negedge clk) begin
        if (!adc_wr_n) begin
            adc_int_n  = 1'b1;
            converting = 0;
            seen_ctl   = adc_data_out;
            wr_low_len++;
        end
        if (!prev_wr_n && adc_wr_n) begin
            converting  = 1;
            mcnt        = 0;
            write_count++;
            last_wr_len = wr_low_len;
            wr_low_len  = 0;
        end
        if (converting) begin
            if (mcnt == conv_dly) begin
                adc_int_n  = 1'b0;
                converting = 0;
            end
            mcnt++;
        end
        if (!adc_rd_n) adc_int_n = 1'b1;
        prev_wr_n = adc_wr_n;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          is_err;
        logic [11:0] val;
        logic [2:0]  ch;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   done_cnt = 0;
    logic pv = 1'b0, pe = 1'b0;

    always @(negedge clk) begin
        if (!rst && ((smp_valid && !pv) || (err_timeout && !pe))) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6/R7 unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_err) begin
                    chk(err_timeout == 1'b1, {e.tag, " R7 err flag"}, err_timeout, 1);
                    chk(smp_valid == 1'b0, {e.tag, " R7 no sample"}, smp_valid, 0);
                end else begin
                    chk(smp_valid == 1'b1 && err_timeout == 1'b0,
                        {e.tag, " R8 sample not error"}, {smp_valid, err_timeout}, 2);
                    chk(smp_data12 == e.val, {e.tag, " R3 R4 data12"}, smp_data12, e.val);
                    chk(smp_data16 == {{4{e.val[11]}}, e.val}, {e.tag, " R4 data16"},
                        smp_data16, {{4{e.val[11]}}, e.val});
                    chk(smp_chan == e.ch, {e.tag, " R5 chan"}, smp_chan, e.ch);
                    chk(stat_done_n == 1'b0, {e.tag, " R6 status low"}, stat_done_n, 0);
                end
            end
            done_cnt++;
        end
        pv = smp_valid;
        pe = err_timeout;
    end

    // ---------------- driver ----------------
    task automatic host_write(input logic [7:0] b);
        @(negedge clk);
        host_wr_data  = b;
        host_wr_valid = 1'b1;
        @(negedge clk);
        host_wr_valid = 1'b0;
    endtask

    task automatic convert(input logic [7:0] ctl, input logic [11:0] val,
                           input int dly, input bit is_err, input string tag);
        exp_t e;
        int start;
        int wc;
        e.is_err = is_err; e.val = val; e.ch = ctl[2:0]; e.tag = tag;
        exp_q.push_back(e);
        res12 = val;
        conv_dly = dly;
        start = done_cnt;
        wc = write_count;
        host_write(ctl);
        chk(smp_valid == 1'b0 && stat_done_n == 1'b1, {tag, " R6 cleared on accept"},
            {smp_valid, stat_done_n}, 1);
        chk(err_timeout == 1'b0, {tag, " R7 err cleared on accept"}, err_timeout, 0);
        while (done_cnt == start) @(negedge clk);
        chk(write_count == wc + 1, {tag, " R2 one write"}, write_count, wc + 1);
        chk(seen_ctl == ctl, {tag, " R2 byte seen"}, seen_ctl, ctl);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog requirement=all actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(adc_cs_n && adc_wr_n && adc_rd_n && !adc_hben && !adc_data_oe,
            "R1 bus idle in reset", {adc_cs_n, adc_wr_n, adc_rd_n, adc_hben, adc_data_oe}, 5'b11100);
        rst = 1'b0;
        @(negedge clk);
        chk(!smp_valid && stat_done_n && !err_timeout && !busy_reject,
            "R1 flags after reset", {smp_valid, stat_done_n, err_timeout, busy_reject}, 4'b0100);
        chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1 strobes high", {adc_cs_n, adc_wr_n, adc_rd_n}, 3'b111);

        convert(8'h48, 12'h5A3, 5, 0, "t1");
        chk(last_wr_len == WRC, "R2 write width", last_wr_len, WRC);
        repeat (5) @(negedge clk);
        chk(smp_valid && !stat_done_n, "R6 held while idle", {smp_valid, stat_done_n}, 2);

        convert(8'h4F, 12'h800, 3, 0, "t2");
        convert(8'h4B, 12'h7FF, 0, 0, "t3");
        convert(8'h4A, 12'hFFF, 8, 0, "t4");
        convert(8'h4C, 12'h000, 2, 0, "t4b");

        // R7: no completion at all
        convert(8'h49, 12'h123, 100000, 1, "t5");
        repeat (4) @(negedge clk);
        chk(err_timeout && !smp_valid, "R7 err held", {err_timeout, smp_valid}, 2);

        // R8: tie resolved in favour of completion; one clock later times out
        convert(8'h4D, 12'h9C1, TOUT - 3, 0, "t6 R8 tie");
        convert(8'h4E, 12'h3E7, TOUT - 2, 1, "t7 R8 late");

        // R9: write during a conversion is ignored
        begin
            exp_t e;
            int start;
            int wc;
            e.is_err = 0; e.val = 12'h2B4; e.ch = 3'd1; e.tag = "t8 R9";
            exp_q.push_back(e);
            res12 = 12'h2B4;
            conv_dly = 12;
            start = done_cnt;
            wc = write_count;
            host_write(8'h49);
            repeat (4) @(negedge clk);
            host_write(8'h4E);
            chk(busy_reject == 1'b1, "R9 busy pulse", busy_reject, 1);
            @(negedge clk);
            chk(busy_reject == 1'b0, "R9 pulse one clock", busy_reject, 0);
            while (done_cnt == start) @(negedge clk);
            chk(write_count == wc + 1, "R9 no second converter write", write_count, wc + 1);
            chk(seen_ctl == 8'h49, "R9 converter byte unchanged", seen_ctl, 8'h49);
        end

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule